// File: doc/BRIEF.md
# Banked External Memory Page Selector

This block widens a 64K-word external memory window to eight banks of 64K words each, 512K words in all. A 3-bit page register picks one bank. A decoder turns the page value into eight active-low bank chip selects. A chip select is driven low only while the shared access strobe is active.

Software changes pages through a guarded sequence. First it drives the unlock line low from a general-purpose output. Then it performs one external write whose low three data bits carry the new page number. Finally it drives unlock high again. The page register takes the data on the clock after the write strobe returns high, so the loading write still reaches the bank that was selected before the switch. One word per bank is therefore lost to page switching.

An optional gated write strobe keeps other external devices from seeing writes while unlock is low.

Top module: `bank_page_sel`

## Requirements
- R1: After reset, and on any later reset, the page output is 0. With the access strobe inactive (high), all eight chip selects are high.
- R2: When the active-low write strobe goes from low to high while unlock is low, the page output takes the value of the 3-bit data input on the next clock edge. The rising strobe is seen when one clock samples it low and the next clock samples it high.
- R3: The page is not loaded when unlock is sampled high on the clock where the strobe's rising edge is seen. This holds even if unlock was low while the strobe was low.
- R4: While the write strobe is low, the page output keeps its old value. The chip select of the previously selected bank stays active for the whole loading write.
- R5: While the access strobe is low, exactly one chip select is low, and it is the one whose index equals the page value (bit k of the chip-select bus belongs to bank k). While the access strobe is high, all chip selects are high.
- R6: With no rising edge of the write strobe, the page holds its value, even when unlock toggles.
- R7: When the inhibit variant is selected (the default), the gated write output follows the write strobe while unlock is high and is held high while unlock is low.
- R8: All eight page values 0 to 7 can be loaded, and each one selects its own bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| unlock_n_i | input | 1 | Active-low page-load enable, driven from a general-purpose output |
| wr_n_i | input | 1 | Active-low external write strobe |
| data_i | input | PAGE_W (3) | Low data bits of the external bus |
| acc_n_i | input | 1 | Active-low external access strobe |
| cs_n_o | output | 2**PAGE_W (8) | Active-low bank chip selects, bit k for bank k |
| page_o | output | PAGE_W (3) | Current page |
| ext_wr_n_o | output | 1 | Write strobe for other external devices, gated by unlock |

## Verification
The page register is the block's only state, and every access shows it at the ports: a wrong page value moves the low chip select to a different bank as soon as the access strobe goes low. A load taken on the wrong edge or without unlock shows on page_o one clock after the strobe rises. A load taken too early shows on the chip selects while the loading write is still in its low phase. The checks therefore read the chip selects during the write's low phase and the page one clock after the strobe rises, across accepted loads, refused loads and the delayed-release case where unlock goes high before the strobe does.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

  // Observed level of the write strobe on the previous clock.
  typedef enum logic {
    STB_HIGH = 1'b1,
    STB_LOW  = 1'b0
  } stb_state_t;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/bsel_rst_sync.sv
module bsel_rst_sync
  import bank_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/bsel_strobe_edge.sv
module bsel_strobe_edge
  import bank_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic rise
);

  stb_state_t st_q;
  stb_state_t st_d;

  always_comb begin
    st_d = wr_n ? STB_HIGH : STB_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= STB_HIGH;
    else        st_q <= st_d;
  end

  // Strobe seen low last clock and high now: the write is completing.
  assign rise = (st_q == STB_LOW) && wr_n;

endmodule

// File: rtl/bsel_page_reg.sv
module bsel_page_reg #(
  parameter int unsigned PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic              unlock_n,
  input  logic [PAGE_W-1:0] data,
  output logic [PAGE_W-1:0] page
);

  logic              load_en;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    load_en = wr_done && !unlock_n;
    page_d  = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (load_en) page_q <= page_d;
  end

  assign page = page_q;

endmodule

// File: rtl/bsel_bank_dec.sv
module bsel_bank_dec #(
  parameter int unsigned PAGE_W = 3,
  localparam int unsigned NUM_BANKS = 1 << PAGE_W
) (
  input  logic [PAGE_W-1:0]    page,
  input  logic                 acc_n,
  output logic [NUM_BANKS-1:0] cs_n
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign cs_n[b] = !(!acc_n && (page == PAGE_W'(b)));
  end

endmodule

// File: rtl/bank_page_sel.sv
module bank_page_sel #(
  parameter int unsigned PAGE_W     = 3,
  parameter bit          INHIBIT_EN = 1'b1,
  localparam int unsigned NUM_BANKS = 1 << PAGE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 unlock_n_i,
  input  logic                 wr_n_i,
  input  logic [PAGE_W-1:0]    data_i,
  input  logic                 acc_n_i,
  output logic [NUM_BANKS-1:0] cs_n_o,
  output logic [PAGE_W-1:0]    page_o,
  output logic                 ext_wr_n_o
);

  logic rst_sync_n;
  logic wr_done;

  bsel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  bsel_strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_n  (wr_n_i),
    .rise  (wr_done)
  );

  bsel_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_done  (wr_done),
    .unlock_n (unlock_n_i),
    .data     (data_i),
    .page     (page_o)
  );

  bsel_bank_dec #(.PAGE_W(PAGE_W)) u_dec (
    .page  (page_o),
    .acc_n (acc_n_i),
    .cs_n  (cs_n_o)
  );

  if (INHIBIT_EN) begin : g_inhibit
    assign ext_wr_n_o = wr_n_i || !unlock_n_i;
  end else begin : g_pass
    assign ext_wr_n_o = wr_n_i;
  end

endmodule

// File: rtl/bank_page_sel_chk.sv
module bank_page_sel_chk #(
  parameter int unsigned PAGE_W     = 3,
  parameter bit          INHIBIT_EN = 1'b1,
  localparam int unsigned NUM_BANKS = 1 << PAGE_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 unlock_n,
  input logic                 wr_n,
  input logic [PAGE_W-1:0]    data,
  input logic                 acc_n,
  input logic [NUM_BANKS-1:0] cs_n,
  input logic [PAGE_W-1:0]    page,
  input logic                 ext_wr_n
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlock_n && wr_n && !$past(wr_n)) |=> (page == $past(data)));

  p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_n |=> $stable(page));

  p_old_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> $stable(page));

  p_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_n |-> ($countones(~cs_n) == 1 && !cs_n[page]));

  p_idle_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_n |-> (&cs_n));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_n && !$past(wr_n)) |=> $stable(page));

  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (INHIBIT_EN && !unlock_n) |-> ext_wr_n);

endmodule

bind bank_page_sel bank_page_sel_chk #(
  .PAGE_W     (PAGE_W),
  .INHIBIT_EN (INHIBIT_EN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .unlock_n (unlock_n_i),
  .wr_n     (wr_n_i),
  .data     (data_i),
  .acc_n    (acc_n_i),
  .cs_n     (cs_n_o),
  .page     (page_o),
  .ext_wr_n (ext_wr_n_o)
);

// File: tb/bank_page_sel_tb.sv
`timescale 1ns/100ps
module bank_page_sel_tb;

  localparam int unsigned PW = 3;
  localparam int unsigned NB = 1 << PW;
  localparam int unsigned NVEC = 8;
  // {unlock_n, data[2:0], expected page after the write}
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b0, 3'd5, 3'd5},
    {1'b1, 3'd3, 3'd5},
    {1'b0, 3'd0, 3'd0},
    {1'b0, 3'd7, 3'd7},
    {1'b1, 3'd0, 3'd7},
    {1'b0, 3'd2, 3'd2},
    {1'b0, 3'd6, 3'd6},
    {1'b0, 3'd1, 3'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          unlock_n;
  logic          wr_n;
  logic [PW-1:0] data;
  logic          acc_n;
  logic [NB-1:0] cs_n;
  logic [PW-1:0] page;
  logic          ext_wr_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bank_page_sel u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .unlock_n_i (unlock_n),
    .wr_n_i     (wr_n),
    .data_i     (data),
    .acc_n_i    (acc_n),
    .cs_n_o     (cs_n),
    .page_o     (page),
    .ext_wr_n_o (ext_wr_n)
  );

  function automatic logic [NB-1:0] sel_of(input logic [PW-1:0] p);
    return ~(NB'(1) << p);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One external write; checks the old bank during the low phase and the page after.
  task automatic ext_write(input logic u, input logic [PW-1:0] d,
                           input logic [PW-1:0] old_p, input logic [PW-1:0] new_p,
                           input string req);
    @(negedge clk);
    unlock_n = u; data = d; acc_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); #1;
    check("R4 old bank selected during write", 32'(cs_n), 32'(sel_of(old_p)));
    check("R4 page unchanged during write", 32'(page), 32'(old_p));
    wr_n = 1'b1;
    @(negedge clk); #1;
    check(req, 32'(page), 32'(new_p));
    check("R5 chip select follows page", 32'(cs_n), 32'(sel_of(new_p)));
    acc_n = 1'b1; unlock_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] cur;
    rst_n = 1'b0; unlock_n = 1'b1; wr_n = 1'b1; data = '0; acc_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset page", 32'(page), 32'd0);
    check("R1 idle selects high", 32'(cs_n), 32'(NB'('1)));
    acc_n = 1'b0; #1;
    check("R5 bank 0 after reset", 32'(cs_n), 32'(sel_of(3'd0)));
    acc_n = 1'b1;

    // Vector table: R2 accepted loads, R3 refused loads
    cur = '0;
    for (int i = 0; i < NVEC; i++) begin
      ext_write(VEC[i][6], VEC[i][5:3], cur, VEC[i][2:0],
                VEC[i][6] ? "R3 locked write ignored" : "R2 page load");
      cur = VEC[i][2:0];
    end

    // R6: unlock toggles without any write
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); unlock_n = 1'b0; data = 3'd4;
      @(negedge clk); unlock_n = 1'b1;
    end
    @(negedge clk); #1;
    check("R6 page holds without write", 32'(page), 32'(cur));

    // R3: unlock released before the strobe rises
    @(negedge clk); unlock_n = 1'b0; data = 3'd3; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    unlock_n = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); #1;
    check("R3 unlock high at release refuses load", 32'(page), 32'(cur));

    // R7: gated write output
    @(negedge clk); unlock_n = 1'b1; wr_n = 1'b0; #1;
    check("R7 gated write passes when locked", 32'(ext_wr_n), 32'd0);
    unlock_n = 1'b0; #1;
    check("R7 gated write blocked when unlocked", 32'(ext_wr_n), 32'd1);
    unlock_n = 1'b1; #1;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); #1;
    check("R7 locked write leaves page", 32'(page), 32'(cur));

    // R8: every bank reachable
    for (int k = 0; k < NB; k++) begin
      ext_write(1'b0, PW'(k), cur, PW'(k), "R8 bank reachable");
      cur = PW'(k);
    end

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 reset clears page", 32'(page), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 page stays 0 after release", 32'(page), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule